// File: doc/BRIEF.md
# Asynchronous Serial Transceiver

This block is a start-stop serial unit with two independent channels: a transmitter that drives `txd` and a receiver that watches `rxd`. Running both at once gives full-duplex traffic over separate lines. Both channels share one programmable baud divider. The divider produces one tick per oversample period, and every bit on the line lasts 16 ticks.

Character format is chosen at run time through plain configuration pins. The character can be 5, 7 or 8 data bits long. The bit order can be MSB-first or LSB-first, the data bits can be inverted on the line, and four parity modes are available. Data enters through a valid/ready port. `tx_ready` is high only while the single holding register is empty, and a word is taken on any clock edge where `tx_valid` and `tx_ready` are both high.

Received characters leave through a second valid/ready port. `rx_valid` stays high, and `rx_data` and `rx_err` stay unchanged, until the consumer asserts `rx_ready`. If the consumer stalls, the receiver does not wait: a character that completes while the previous one is still unread is dropped and recorded as an overrun. Framing, parity and overrun problems are reported three ways: as sticky flags, as a one-cycle error interrupt, and through a per-character `rx_err` mark.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1 (given a valid length code), `rx_valid` is 0, and every error flag is 0.
- R2: A transmitted character appears on `txd` in this order: a start bit of 0, the data bits, the parity bit (if enabled), and a stop bit of 1. Each bit lasts 16*(`baud_div`+1) clocks. The first bit may be up to `baud_div` clocks shorter.
- R3: `cfg_len` selects the data length: 00 gives 5 bits, 10 gives 7 bits, 11 gives 8 bits. A received character is returned in the low bits of `rx_data`, and the bits above it are 0.
- R4: `cfg_len` = 01 is a configuration error. While it is applied, `err_cfg` is 1, `tx_ready` is 0, and the receiver ignores `rxd`.
- R5: With `cfg_msb_first` = 1, the highest data bit of the character is first on the line. With `cfg_msb_first` = 0, bit 0 is first. Both channels follow the setting.
- R6: With `cfg_invert` = 1, the data bits are inverted on the line in both directions. The start, parity and stop bits are not inverted, and parity is always computed on the true data.
- R7: `cfg_parity` selects the parity mode: 00 none, 01 parity bit always 0, 10 even (the parity bit makes the count of ones even), 11 odd.
- R8: A received parity bit that differs from the expected value gives the following: the character is delivered with `rx_err` = 1, `err_parity` is set, and `err_irq` pulses for one cycle.
- R9: A stop bit received as 0 gives the following: the character is delivered with `rx_err` = 1, `err_frame` is set, and `err_irq` pulses.
- R10: A character that completes while `rx_valid` is high and `rx_ready` is low is discarded. `err_overrun` is set and `err_irq` pulses. The unread character keeps `rx_err` = 0 and remains unchanged.
- R11: The receiver takes each bit as the majority of oversamples 7, 8 and 9. If the start bit is not still low at mid-bit, the receiver returns to idle and delivers nothing.
- R12: With `cfg_irq_end` = 0, `tx_irq` pulses when a word moves from the holding register into the shifter. With `cfg_irq_end` = 1, it pulses when the stop bit of a character ends.
- R13: The error flags stay set until `err_clear` is asserted. If a flag is set in the same cycle as a clear, the set wins.
- R14: After a word is accepted, `tx_ready` is 0 until the holding register empties. `rx_valid`, `rx_data` and `rx_err` hold steady until `rx_ready` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Divider reload; one tick every baud_div+1 clocks |
| cfg_len | input | 2 | Data length code |
| cfg_msb_first | input | 1 | 1 = MSB first on the line |
| cfg_invert | input | 1 | Invert data bits on the line |
| cfg_parity | input | 2 | Parity mode |
| cfg_irq_end | input | 1 | tx_irq source: 0 buffer empty, 1 transfer end |
| tx_data | input | 8 | Word to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Holding register free |
| txd | output | 1 | Serial output, idle 1 |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | rx_data is offered |
| rx_ready | input | 1 | Consumer takes rx_data |
| rx_err | output | 1 | Offered character had a framing or parity error |
| tx_irq | output | 1 | Transmit interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_clear | input | 1 | Clears the sticky flags |
| err_cfg | output | 1 | Length code 01 applied |

## Verification
After an accepted word, the start bit appears on `txd` one edge after the holding register loads. With the default divider, the buffer-empty pulse lands on that same edge, and the transfer-end pulse lands one edge after the last oversample tick of the stop bit. A received character surfaces about 12 clocks into its stop bit: two synchroniser stages plus the mid-bit vote. The error flag and `err_irq` rise on that same edge. Because the divider phase is free-running, the bench does not count exact edges for line-driven results. It reads serial bits at mid-bit after detecting the start edge, polls for `rx_valid` within a bounded window, and checks the interrupt delays against windows derived from the frame length.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  typedef enum logic [1:0] {PAR_NONE = 2'b00, PAR_ZERO = 2'b01, PAR_EVEN = 2'b10, PAR_ODD = 2'b11} par_mode_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_phase_e;

  // length code to data bit count; code 01 is rejected by the top
  function automatic logic [3:0] len_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd5;
      2'b10:   return 4'd7;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_xcvr_baud.sv
module uart_xcvr_baud #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == '0)  cnt <= div;
    else                 cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);

  AST_BAUD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div != '0) |=> !tick); // R2
endmodule

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
  import uart_xcvr_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_ok,
  input  logic [3:0]    nbits,
  input  logic          msb,
  input  logic          inv,
  input  par_mode_e     par,
  input  logic          irq_end,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          txd,
  output logic          tx_irq
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DW);
  localparam int LW = $clog2(FW + 1);

  logic [DW-1:0] hold_q;
  logic          hold_full, busy;
  logic [FW-1:0] shreg, frame_d;
  logic [LW-1:0] left, nb_d;
  logic [CW-1:0] ph;
  logic          ones, load, last_edge;
  logic [3:0]    src;

  assign tx_ready  = cfg_ok && !hold_full;
  assign load      = hold_full && !busy;
  assign last_edge = busy && tick && (ph == CW'(OSR - 1)) && (left == LW'(1));
  assign txd       = busy ? shreg[0] : 1'b1;

  // frame assembled in line order, bit 0 leaves first
  always_comb begin
    frame_d    = '1;
    frame_d[0] = 1'b0;
    ones       = 1'b0;
    src        = '0;
    for (int i = 0; i < DW; i++) begin
      if (4'(i) < nbits) begin
        src          = msb ? (nbits - 4'd1 - 4'(i)) : 4'(i);
        frame_d[i+1] = hold_q[IW'(src)] ^ inv;
        ones         = ones ^ hold_q[IW'(src)];
      end
    end
    nb_d = LW'(nbits) + LW'(2);
    if (par != PAR_NONE) begin
      nb_d = nb_d + LW'(1);
      case (par)
        PAR_ZERO: frame_d[nbits + 4'd1] = 1'b0;
        PAR_EVEN: frame_d[nbits + 4'd1] = ones;
        default:  frame_d[nbits + 4'd1] = ~ones;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      shreg     <= '1;
      left      <= '0;
      ph        <= '0;
      tx_irq    <= 1'b0;
    end else begin
      tx_irq <= irq_end ? last_edge : load;
      if (load) begin
        shreg     <= frame_d;
        left      <= nb_d;
        ph        <= '0;
        busy      <= 1'b1;
        hold_full <= 1'b0;
      end else if (tx_valid && tx_ready) begin
        hold_q    <= tx_data;
        hold_full <= 1'b1;
      end
      if (busy && tick) begin
        if (ph == CW'(OSR - 1)) begin
          ph    <= '0;
          shreg <= {1'b1, shreg[FW-1:1]};
          left  <= left - LW'(1);
          if (left == LW'(1)) busy <= 1'b0;
        end else begin
          ph <= ph + CW'(1);
        end
      end
    end
  end

  AST_TX_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready); // R14
  AST_TX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R12
endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
  import uart_xcvr_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_ok,
  input  logic [3:0]    nbits,
  input  logic          msb,
  input  logic          inv,
  input  par_mode_e     par,
  input  logic          rxd_s,
  input  logic          rx_ready,
  input  logic          err_clear,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_err,
  output logic          err_frame,
  output logic          err_parity,
  output logic          err_overrun,
  output logic          err_irq
);
  localparam int CW  = $clog2(OSR);
  localparam int IW  = $clog2(DW);
  localparam int MID = OSR / 2;

  rx_phase_e     phase;
  logic [CW-1:0] ph;
  logic [3:0]    idx;
  logic [DW-1:0] acc;
  logic          s_a, s_b, pacc, perr;
  logic          vote, par_exp, ferr, bitv;
  logic [IW-1:0] pos;

  assign vote    = (s_a & s_b) | (s_a & rxd_s) | (s_b & rxd_s);
  assign bitv    = vote ^ inv;
  assign pos     = msb ? IW'(nbits - 4'd1 - idx) : IW'(idx);
  assign par_exp = (par == PAR_ZERO) ? 1'b0 : (par == PAR_EVEN) ? pacc : ~pacc;
  assign ferr    = !vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= RX_IDLE;
      ph          <= '0;
      idx         <= '0;
      acc         <= '0;
      s_a         <= 1'b1;
      s_b         <= 1'b1;
      pacc        <= 1'b0;
      perr        <= 1'b0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_err      <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      err_irq     <= 1'b0;
    end else begin
      err_irq <= 1'b0;
      if (err_clear) begin
        err_frame   <= 1'b0;
        err_parity  <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (tick) begin
        if (phase == RX_IDLE) begin
          ph <= '0;
          if (cfg_ok && !rxd_s) phase <= RX_START;
        end else begin
          ph <= (ph == CW'(OSR - 1)) ? '0 : ph + CW'(1);
          if (ph == CW'(MID - 1)) s_a <= rxd_s;
          if (ph == CW'(MID))     s_b <= rxd_s;
          if (ph == CW'(MID + 1)) begin
            case (phase)
              RX_START: if (vote) phase <= RX_IDLE;
              RX_DATA: begin
                acc[pos] <= bitv;
                pacc     <= pacc ^ bitv;
              end
              RX_PAR:  perr <= (vote != par_exp);
              RX_STOP: begin
                phase <= RX_IDLE;
                if (rx_valid && !rx_ready) begin
                  err_overrun <= 1'b1;
                  err_irq     <= 1'b1;
                end else begin
                  rx_data  <= acc;
                  rx_valid <= 1'b1;
                  rx_err   <= ferr | perr;
                  if (ferr)        err_frame  <= 1'b1;
                  if (perr)        err_parity <= 1'b1;
                  if (ferr | perr) err_irq    <= 1'b1;
                end
              end
              default: ;
            endcase
          end
          if (ph == CW'(OSR - 1)) begin
            case (phase)
              RX_START: begin
                phase <= RX_DATA;
                idx   <= '0;
                acc   <= '0;
                pacc  <= 1'b0;
                perr  <= 1'b0;
              end
              RX_DATA: begin
                if (idx == nbits - 4'd1) phase <= (par != PAR_NONE) ? RX_PAR : RX_STOP;
                else                     idx   <= idx + 4'd1;
              end
              RX_PAR:  phase <= RX_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_err)); // R14
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun && !err_clear |=> err_overrun); // R13
  AST_PAR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> err_irq); // R8
  AST_FRM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> err_irq); // R9
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 16,
  parameter int OSR  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] baud_div,
  input  logic [1:0]      cfg_len,
  input  logic            cfg_msb_first,
  input  logic            cfg_invert,
  input  logic [1:0]      cfg_parity,
  input  logic            cfg_irq_end,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic            txd,
  input  logic            rxd,
  output logic [DW-1:0]   rx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic            rx_err,
  output logic            tx_irq,
  output logic            err_irq,
  output logic            err_frame,
  output logic            err_parity,
  output logic            err_overrun,
  input  logic            err_clear,
  output logic            err_cfg
);
  logic       tick, cfg_ok;
  logic [1:0] rxd_sync;
  logic [3:0] nbits;
  par_mode_e  par;

  assign err_cfg = (cfg_len == 2'b01);
  assign cfg_ok  = !err_cfg;
  assign nbits   = len_bits(cfg_len);
  assign par     = par_mode_e'(cfg_parity);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxd_sync <= 2'b11;
    else        rxd_sync <= {rxd_sync[0], rxd};
  end

  uart_xcvr_baud #(.DIVW(DIVW)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_xcvr_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_ok(cfg_ok), .nbits(nbits),
    .msb(cfg_msb_first), .inv(cfg_invert), .par(par), .irq_end(cfg_irq_end),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .tx_irq(tx_irq)
  );

  uart_xcvr_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_ok(cfg_ok), .nbits(nbits),
    .msb(cfg_msb_first), .inv(cfg_invert), .par(par), .rxd_s(rxd_sync[1]),
    .rx_ready(rx_ready), .err_clear(err_clear), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_err(rx_err), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun), .err_irq(err_irq)
  );

  AST_CFG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_cfg |-> !tx_ready); // R4
endmodule

// File: tb/uart_xcvr_test.sv
module uart_xcvr_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] baud_div = '0;
  logic [1:0]  cfg_len = 2'b11;
  logic        cfg_msb_first = 1'b0, cfg_invert = 1'b0, cfg_irq_end = 1'b0;
  logic [1:0]  cfg_parity = 2'b00;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0, rx_ready = 1'b0, err_clear = 1'b0;
  logic        tx_ready, txd, rx_valid, rx_err, tx_irq, err_irq;
  logic        err_frame, err_parity, err_overrun, err_cfg;
  logic [7:0]  rx_data;
  logic        lb = 1'b0, rxd_drv = 1'b1;
  wire         rxd_w = lb ? txd : rxd_drv;

  int checks = 0, errors = 0, cyc = 0;
  int tx_irq_n = 0, tx_irq_at = 0, err_irq_n = 0;

  uart_xcvr uut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .cfg_len(cfg_len),
    .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert), .cfg_parity(cfg_parity),
    .cfg_irq_end(cfg_irq_end), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .rxd(rxd_w), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_err(rx_err), .tx_irq(tx_irq),
    .err_irq(err_irq), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .err_clear(err_clear), .err_cfg(err_cfg)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (tx_irq) begin tx_irq_n <= tx_irq_n + 1; tx_irq_at <= cyc; end
    if (err_irq) err_irq_n <= err_irq_n + 1;
  end

  // {len[1:0], msb, inv, par[1:0], 2'b00, data[7:0]}
  localparam logic [15:0] VEC [7] = '{
    {2'b11, 1'b0, 1'b0, 2'b00, 2'b00, 8'hA5},
    {2'b11, 1'b1, 1'b0, 2'b10, 2'b00, 8'h3C},
    {2'b10, 1'b0, 1'b1, 2'b11, 2'b00, 8'h5B},
    {2'b00, 1'b1, 1'b0, 2'b01, 2'b00, 8'h13},
    {2'b00, 1'b0, 1'b1, 2'b10, 2'b00, 8'hFF},
    {2'b10, 1'b1, 1'b1, 2'b00, 2'b00, 8'h6E},
    {2'b11, 1'b0, 1'b0, 2'b11, 2'b00, 8'h80}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] code);
    return (code == 2'b00) ? 5 : (code == 2'b10) ? 7 : 8;
  endfunction

  function automatic logic [10:0] mk_frame(input logic [7:0] d, input logic [1:0] len,
      input logic msb, input logic inv, input logic [1:0] par, output int nb);
    int L = len_of(len);
    logic [10:0] f = '1;
    logic p = 1'b0;
    f[0] = 1'b0;
    for (int i = 0; i < L; i++) begin
      logic b;
      b = msb ? d[L-1-i] : d[i];
      f[1+i] = b ^ inv;
      p = p ^ b;
    end
    nb = L + 2;
    if (par != 2'b00) begin
      f[1+L] = (par == 2'b01) ? 1'b0 : (par == 2'b10) ? p : ~p;
      nb++;
    end
    return f;
  endfunction

  task automatic set_cfg(input logic [1:0] len, input logic msb, input logic inv, input logic [1:0] par);
    @(negedge clk);
    cfg_len = len; cfg_msb_first = msb; cfg_invert = inv; cfg_parity = par;
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic grab_tx(input int nb, output logic [10:0] f);
    int guard = 0;
    f = '1;
    while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      f[i] = txd;
      repeat (16) @(negedge clk);
    end
  endtask

  task automatic drive_rx(input logic [10:0] f, input int nb);
    for (int i = 0; i < nb; i++) begin
      rxd_drv = f[i];
      repeat (16) @(negedge clk);
    end
    rxd_drv = 1'b1;
  endtask

  task automatic wait_rx(input int lim);
    for (int i = 0; i < lim && !rx_valid; i++) @(negedge clk);
  endtask

  task automatic read_rx;
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clear_err;
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [10:0] f, got;
    int nb, base, t0, w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 txd idle", txd, 1);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 flags", {err_frame, err_parity, err_overrun, err_cfg}, 0);

    // table walk with loopback: R2 R3 R5 R6 R7
    lb = 1'b1;
    foreach (VEC[k]) begin
      set_cfg(VEC[k][15:14], VEC[k][13], VEC[k][12], VEC[k][11:10]);
      f = mk_frame(VEC[k][7:0], VEC[k][15:14], VEC[k][13], VEC[k][12], VEC[k][11:10], nb);
      send_tx(VEC[k][7:0]);
      grab_tx(nb, got);
      check($sformatf("R2 R5 R6 R7 tx frame vec %0d", k), int'(got & ((11'd1 << nb) - 1)),
            int'(f & ((11'd1 << nb) - 1)));
      wait_rx(100);
      check($sformatf("R3 R5 R6 rx data vec %0d", k), rx_data,
            VEC[k][7:0] & 8'((9'd1 << len_of(VEC[k][15:14])) - 1));
      check($sformatf("R7 rx clean vec %0d", k), rx_err, 0);
      read_rx();
      repeat (20) @(negedge clk);
    end
    lb = 1'b0;

    // R2 bit width with divider 1
    @(negedge clk); baud_div = 16'd1;
    set_cfg(2'b11, 1'b0, 1'b0, 2'b00);
    send_tx(8'hFF);
    w = 0;
    while (txd !== 1'b0 && w < 100) begin @(negedge clk); w++; end
    w = 0;
    while (txd === 1'b0 && w < 100) begin @(negedge clk); w++; end
    check("R2 start bit width", (w >= 31 && w <= 32), 1);
    repeat (400) @(negedge clk);
    @(negedge clk); baud_div = 16'd0;

    // R8 parity error
    set_cfg(2'b11, 1'b0, 1'b0, 2'b10);
    f = mk_frame(8'h71, 2'b11, 1'b0, 1'b0, 2'b10, nb);
    f[9] = ~f[9];
    base = err_irq_n;
    drive_rx(f, nb);
    wait_rx(50);
    check("R8 char marked", {rx_valid, rx_err}, 2'b11);
    check("R8 flags", {err_frame, err_parity, err_overrun}, 3'b010);
    check("R8 err_irq once", err_irq_n - base, 1);
    read_rx();
    clear_err();
    check("R13 cleared", {err_frame, err_parity, err_overrun}, 0);

    // R9 framing error
    set_cfg(2'b11, 1'b0, 1'b0, 2'b00);
    f = mk_frame(8'h42, 2'b11, 1'b0, 1'b0, 2'b00, nb);
    f[9] = 1'b0;
    drive_rx(f, nb);
    wait_rx(50);
    check("R9 char marked", {rx_valid, rx_err, rx_data}, {2'b11, 8'h42});
    check("R9 flags", {err_frame, err_parity, err_overrun}, 3'b100);
    repeat (5) @(negedge clk);
    check("R13 frame flag sticky", err_frame, 1);
    read_rx();
    repeat (300) @(negedge clk);
    clear_err();

    // R10 overrun
    base = err_irq_n;
    f = mk_frame(8'h11, 2'b11, 1'b0, 1'b0, 2'b00, nb);
    drive_rx(f, nb);
    f = mk_frame(8'h22, 2'b11, 1'b0, 1'b0, 2'b00, nb);
    drive_rx(f, nb);
    repeat (20) @(negedge clk);
    check("R10 R14 old char kept", {rx_valid, rx_err, rx_data}, {2'b10, 8'h11});
    check("R10 overrun flag", err_overrun, 1);
    check("R10 err_irq", err_irq_n - base, 1);
    read_rx();
    repeat (3) @(negedge clk);
    check("R10 new char dropped", rx_valid, 0);
    clear_err();

    // R11 false start then a real character
    rxd_drv = 1'b0;
    repeat (4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (400) @(negedge clk);
    check("R11 glitch ignored", rx_valid, 0);
    f = mk_frame(8'h5A, 2'b11, 1'b0, 1'b0, 2'b00, nb);
    drive_rx(f, nb);
    wait_rx(50);
    check("R11 recovers", {rx_valid, rx_data}, {1'b1, 8'h5A});
    read_rx();

    // R4 configuration error
    set_cfg(2'b01, 1'b0, 1'b0, 2'b00);
    @(negedge clk);
    check("R4 err_cfg", err_cfg, 1);
    check("R4 tx blocked", tx_ready, 0);
    drive_rx(f, 10);
    repeat (60) @(negedge clk);
    check("R4 rx ignores line", rx_valid, 0);
    set_cfg(2'b11, 1'b0, 1'b0, 2'b00);
    @(negedge clk);
    check("R4 recovered", {err_cfg, tx_ready}, 2'b01);

    // R12 buffer-empty interrupt
    cfg_irq_end = 1'b0;
    base = tx_irq_n;
    send_tx(8'hC3);
    t0 = cyc;
    repeat (400) @(negedge clk);
    check("R12 empty irq count", tx_irq_n - base, 1);
    check("R12 empty irq early", (tx_irq_at - t0 >= 0 && tx_irq_at - t0 < 16), 1);
    // R12 transfer-end interrupt
    @(negedge clk); cfg_irq_end = 1'b1;
    base = tx_irq_n;
    send_tx(8'h3C);
    t0 = cyc;
    repeat (400) @(negedge clk);
    check("R12 end irq count", tx_irq_n - base, 1);
    check("R12 end irq late", (tx_irq_at - t0 >= 158 && tx_irq_at - t0 <= 166), 1);

    // R14 back-pressure on the transmit port
    send_tx(8'h01);
    send_tx(8'h02);
    check("R14 ready low after second", tx_ready, 0);
    repeat (50) @(negedge clk);
    check("R14 ready still low", tx_ready, 0);
    repeat (400) @(negedge clk);
    check("R14 ready back", tx_ready, 1);

    finish_run();
  end
endmodule